// File: doc/BRIEF.md
# Registered Bidirectional Port with Handshake Flags

This block connects two 8-bit sides, A and B, through a pair of holding registers, one per direction. The forward register takes a byte from the A side and presents it to the B side. The return register takes a byte from the B side and presents it to the A side. Each register loads under its own active-low load enable and drives its side under its own active-low output enable. Three-state pins are modelled as separate data-in, data-out and drive-enable signals.

Each direction has a "full" flag that supports demand-response transfers. Loading a register raises its flag. The flag drops once the consumer has read the data: its output enable was low on one clock edge and high on the next. Everything runs on one clock.

Bytes leaving on the B side carry a generated odd-parity bit. Bytes arriving from the B side are checked for odd parity. The result of that check is latched with the byte and shown on an active-low error output.

Top module: `dual_hold_port`

## Requirements
- R1: A synchronous active-low reset clears both registers and both flags, and drives `perr_n` high. After reset, `b_par_out` is 1, because the stored byte is zero.
- R2: `b_out` takes the value of `a_in` at a clock edge where `ab_load_n` is 0. It holds that value at every edge where `ab_load_n` is 1.
- R3: `a_out` takes the value of `b_in` at a clock edge where `ba_load_n` is 0. It holds that value at every edge where `ba_load_n` is 1.
- R4: `b_par_out` is chosen so that `b_out` together with `b_par_out` contains an odd number of ones.
- R5: At a load edge of the return register, `perr_n` becomes 0 if `b_in` plus `b_par_in` holds an even number of ones, and 1 otherwise. Between loads it keeps its value, whatever `b_in` and `b_par_in` do.
- R6: A flag (`ab_full` for the forward register, `ba_full` for the return register) is 1 after any edge at which its register loads.
- R7: A flag goes to 0 at an edge where its consumer's output enable is sampled high and was sampled low at the previous edge. Its consumer is `b_oe_n` for `ab_full` and `a_oe_n` for `ba_full`. At any other edge without a load, the flag holds.
- R8: If a load and an output-enable release fall on the same edge, the flag ends up 1.
- R9: `b_drive` is the inverse of `b_oe_n`, and `a_drive` is the inverse of `a_oe_n`, with no clock delay. Neither one affects the stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | 8 | Data arriving from the A side |
| ab_load_n | input | 1 | Load enable of the forward register, active low |
| b_oe_n | input | 1 | Output enable of the B side, active low |
| b_out | output | 8 | Forward register contents toward B |
| b_par_out | output | 1 | Odd-parity bit for `b_out` |
| b_drive | output | 1 | B-side pins driven when 1 |
| ab_full | output | 1 | Forward register holds unread data |
| b_in | input | 8 | Data arriving from the B side |
| b_par_in | input | 1 | Parity bit arriving with `b_in` |
| ba_load_n | input | 1 | Load enable of the return register, active low |
| a_oe_n | input | 1 | Output enable of the A side, active low |
| a_out | output | 8 | Return register contents toward A |
| a_drive | output | 1 | A-side pins driven when 1 |
| ba_full | output | 1 | Return register holds unread data |
| perr_n | output | 1 | Latched parity error of the return byte, active low |

## Verification
A wrong register or parity latch shows on the data and error outputs one edge after the faulty load. It then stays visible until the next load, so every check after a load exposes it. A wrong flag or a wrong stored enable is different: it only shows at a read-release edge or a load edge. The bench therefore walks through read-then-release sequences, releases without a prior read, and releases that coincide with loads, and compares both flags after every edge.

// File: rtl/dual_hold_port.sv
module dual_hold_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic         ab_load_n,
  input  logic         b_oe_n,
  output logic [W-1:0] b_out,
  output logic         b_par_out,
  output logic         b_drive,
  output logic         ab_full,
  input  logic [W-1:0] b_in,
  input  logic         b_par_in,
  input  logic         ba_load_n,
  input  logic         a_oe_n,
  output logic [W-1:0] a_out,
  output logic         a_drive,
  output logic         ba_full,
  output logic         perr_n
);

  logic [W-1:0] ab_q, ba_q;
  logic ab_f, ba_f, perr_q, boe_q, aoe_q;

  // a read ends when the enable was low at the last edge and is high now
  wire b_rel = b_oe_n & ~boe_q;
  wire a_rel = a_oe_n & ~aoe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ab_q   <= '0;
      ba_q   <= '0;
      ab_f   <= 1'b0;
      ba_f   <= 1'b0;
      perr_q <= 1'b1;
      boe_q  <= 1'b1;
      aoe_q  <= 1'b1;
    end else begin
      if (!ab_load_n) ab_q <= a_in;
      if (!ba_load_n) begin
        ba_q   <= b_in;
        perr_q <= ^{b_in, b_par_in};
      end
      ab_f  <= ~ab_load_n | (ab_f & ~b_rel);
      ba_f  <= ~ba_load_n | (ba_f & ~a_rel);
      boe_q <= b_oe_n;
      aoe_q <= a_oe_n;
    end
  end

  assign b_out     = ab_q;
  assign b_par_out = ~^ab_q;
  assign b_drive   = ~b_oe_n;
  assign ab_full   = ab_f;
  assign a_out     = ba_q;
  assign a_drive   = ~a_oe_n;
  assign ba_full   = ba_f;
  assign perr_n    = perr_q;

  assert_load_fwd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ab_load_n |=> b_out == $past(a_in));
  assert_load_ret_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ba_load_n |=> a_out == $past(b_in));
  assert_odd_parity_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ^{b_out, b_par_out} == 1'b1);
  assert_perr_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ba_load_n |=> perr_n == ^$past({b_in, b_par_in}));
  assert_perr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ba_load_n |=> $stable(perr_n));
  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ab_load_n |=> ab_full);
  assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_load_n && !b_oe_n) |=> $stable(ab_full));
  assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_load_n && a_oe_n) |=> ba_full);

endmodule

// File: tb/dual_hold_port_tb.sv
module dual_hold_port_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic [7:0] a_in = 0, b_in = 0;
  logic ab_load_n = 1, ba_load_n = 1, b_oe_n = 1, a_oe_n = 1, b_par_in = 0;
  logic [7:0] b_out, a_out;
  logic b_par_out, b_drive, ab_full, a_drive, ba_full, perr_n;

  always #5 clk = ~clk;

  dual_hold_port dut_i (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .ab_load_n(ab_load_n), .b_oe_n(b_oe_n),
    .b_out(b_out), .b_par_out(b_par_out), .b_drive(b_drive), .ab_full(ab_full),
    .b_in(b_in), .b_par_in(b_par_in), .ba_load_n(ba_load_n), .a_oe_n(a_oe_n),
    .a_out(a_out), .a_drive(a_drive), .ba_full(ba_full), .perr_n(perr_n));

  typedef struct {
    logic       rst;
    logic [7:0] bo, ao;
    logic       bp, bd, ad, abf, baf, pe;
  } exp_t;

  exp_t q[$];
  int checks = 0, failures = 0;
  logic [7:0] m_ab = 0, m_ba = 0;
  logic m_abf = 0, m_baf = 0, m_pe = 1, m_boe = 1, m_aoe = 1;
  bit done = 0;

  task automatic cmp(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(logic rst, logic [7:0] a, logic al, logic boe,
                       logic [7:0] b, logic bp, logic bl, logic aoe);
    exp_t e;
    @(negedge clk);
    rst_n = ~rst; a_in = a; ab_load_n = al; b_oe_n = boe;
    b_in = b; b_par_in = bp; ba_load_n = bl; a_oe_n = aoe;
    if (rst) begin
      m_ab = 0; m_ba = 0; m_abf = 0; m_baf = 0; m_pe = 1; m_boe = 1; m_aoe = 1;
    end else begin
      if (!al) m_ab = a;
      if (!bl) begin m_ba = b; m_pe = ^{b, bp}; end
      m_abf = !al ? 1'b1 : ((boe && !m_boe) ? 1'b0 : m_abf);
      m_baf = !bl ? 1'b1 : ((aoe && !m_aoe) ? 1'b0 : m_baf);
      m_boe = boe; m_aoe = aoe;
    end
    e.rst = rst; e.bo = m_ab; e.ao = m_ba; e.bp = ~^m_ab;
    e.bd = ~boe; e.ad = ~aoe; e.abf = m_abf; e.baf = m_baf; e.pe = m_pe;
    q.push_back(e);
  endtask

  // monitor: compare after each edge, away from it
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        if (e.rst) begin
          cmp("R1 b_out", b_out, e.bo);
          cmp("R1 flags", {ab_full, ba_full}, {e.abf, e.baf});
          cmp("R1 perr_n", perr_n, e.pe);
          cmp("R1 b_par_out", b_par_out, e.bp);
        end else begin
          cmp("R2 b_out", b_out, e.bo);
          cmp("R3 a_out", a_out, e.ao);
          cmp("R4 b_par_out", b_par_out, e.bp);
          cmp("R5 perr_n", perr_n, e.pe);
          cmp("R6_R7_R8 ab_full", ab_full, e.abf);
          cmp("R6_R7_R8 ba_full", ba_full, e.baf);
          cmp("R9 drives", {b_drive, a_drive}, {e.bd, e.ad});
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 reset
    drive(1, 8'h00, 1, 0, 8'h00, 0, 1, 0);
    drive(1, 8'h00, 1, 1, 8'h00, 0, 1, 1);
    // R2 load, R6 set, R4 parity of A5
    drive(0, 8'hA5, 0, 1, 8'h00, 0, 1, 1);
    // R2 hold while a_in changes
    drive(0, 8'h5A, 1, 1, 8'hFF, 1, 1, 1);
    // R7 read two cycles, flag holds; then release clears
    drive(0, 8'h11, 1, 0, 8'h00, 0, 1, 1);
    drive(0, 8'h22, 1, 0, 8'h00, 0, 1, 1);
    drive(0, 8'h33, 1, 1, 8'h00, 0, 1, 1);
    drive(0, 8'h44, 1, 1, 8'h00, 0, 1, 1);
    // R8 load coincides with release
    drive(0, 8'h01, 0, 0, 8'h00, 0, 1, 1);
    drive(0, 8'hFF, 0, 1, 8'h00, 0, 1, 1);
    drive(0, 8'h00, 1, 1, 8'h00, 0, 1, 1);
    // R3 and R5: good odd parity, then bad, then hold
    drive(0, 8'h00, 1, 1, 8'h3C, 1, 0, 1);
    drive(0, 8'h00, 1, 1, 8'h3C, 0, 0, 1);
    drive(0, 8'h00, 1, 1, 8'h01, 0, 1, 1);
    drive(0, 8'h00, 1, 1, 8'h80, 1, 0, 1);
    // R7 on the A side, R9 drive toggles
    drive(0, 8'h00, 1, 1, 8'h00, 0, 1, 0);
    drive(0, 8'h00, 1, 1, 8'h00, 0, 1, 1);
    drive(0, 8'h00, 1, 1, 8'h7E, 1, 0, 0);
    drive(0, 8'h00, 1, 0, 8'h00, 0, 0, 1);
    // mixed patterns
    for (int i = 0; i < 40; i++) begin
      drive(0, 8'(i * 37 + 5), i[0], i[1], 8'(i * 91), i[2], i[3] ^ i[0], i[2] ^ i[1]);
    end
    // R1 reset in mid operation
    drive(1, 8'hC3, 0, 0, 8'hC3, 1, 0, 0);
    drive(0, 8'h00, 1, 1, 8'h00, 0, 1, 1);
    repeat (3) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule